// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked system and a 32K x 8 asynchronous static RAM. The RAM has an active-low select, an active-high select, an active-low write strobe and one shared bidirectional data bus. It has no output-enable pin. The system side issues single read or write requests with a valid/ready handshake. The sequencer then drives address, selects and write strobe for a fixed number of clock cycles. For reads it returns the byte with a one-cycle valid pulse. For writes it reports completion with a one-cycle done pulse.

Every interval is given in picoseconds as a parameter and converted to a cycle count, rounded up from the clock period. This covers the read cycle, address access, write cycle, write pulse, output float, data setup and the retention recovery time. Because the RAM has no output enable, its bus direction follows only the write strobe. The sequencer turns on its own data driver only after the strobe has been low long enough for the RAM to float its outputs. It turns the driver off no later than the edge that raises the strobe.

A level request puts the RAM into a low-power retention state. The select chosen by a parameter is held inactive there. When the request drops, a timed lockout runs before new accesses are accepted.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, req_ready is 1, sram_ce_n is 1, sram_ce is 1, sram_we_n is 1, and rsp_rvalid and rsp_wdone are 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 1 only while the sequencer is idle, with the RAM deselected (sram_ce_n = 1) and no retention request present.
- R3: A read holds sram_ce_n = 0 and sram_we_n = 1 for RD_CYC consecutive cycles. RD_CYC is the larger of the read cycle time and the address access time, each divided by the clock period and rounded up: 4 at 70 ns and 20 ns. The bus is sampled on the last of these cycles. rsp_rvalid is 1 for exactly one cycle, the cycle right after, and carries the byte on rsp_rdata.
- R4: A write holds sram_we_n = 0, with sram_ce_n = 0, for WR_CYC consecutive cycles. WR_CYC is the largest of the rounded-up write cycle, the rounded-up write pulse, and the float count plus the data-setup count: 4 at the defaults. rsp_wdone is 1 for exactly one cycle, the first cycle after sram_we_n returns to 1.
- R5: The sequencer drives sram_dq only while sram_ce_n = 0 and sram_we_n = 0. It starts in strobe cycle FLOAT_CYC+1 (cycle 3 at a 30 ns float time) and keeps driving through the last strobe cycle, where the bus carries the request's write byte.
- R6: sram_addr does not change while the RAM stays selected. Between two accesses the RAM is deselected for at least one cycle.
- R7: A high ret_req puts the idle sequencer into retention one cycle later. With RET_STYLE = 0, retention holds sram_ce = 0 and sram_ce_n = 1. With RET_STYLE = 1, it holds sram_ce_n = 1 and sram_ce = 1. A request valid in the same cycle is not taken. An access already in flight completes first.
- R8: Once ret_req falls, req_ready stays 0 and the RAM stays deselected for exactly RCV_CYC cycles. RCV_CYC is the recovery time rounded up to clock cycles. A request held valid across that window is not taken before it ends.
- R9: A byte written to an address is returned by a later read of that address. A second write to the same address replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_rvalid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read byte |
| rsp_wdone | output | 1 | One-cycle write complete |
| ret_req | input | 1 | Retention request (level) |
| sram_addr | output | ADDR_W | RAM address |
| sram_ce_n | output | 1 | RAM active-low select |
| sram_ce | output | 1 | RAM active-high select |
| sram_we_n | output | 1 | RAM active-low write strobe |
| sram_dq | inout | DATA_W | RAM data bus |

## Verification
The hardest state to reach is a retention request that arrives while an access is in flight. The read must still finish, and retention must start only afterwards. The bench starts a read, raises ret_req in the cycle after the handshake, and checks the select pins each cycle. A second hard case is a request held valid through the whole recovery lockout. The bench asserts the request together with ret_req and keeps it asserted. It then counts the cycles until req_ready returns, and confirms that the RAM is never selected in that window.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_RET,
      ST_RCV
   } seq_state_t;

   // Interval in picoseconds to whole clock cycles, rounded up, at least one.
   function automatic int cycles_for(input longint t_ps, input longint clk_ps);
      longint c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : int'(c);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_count.sv
module sram_seq_count #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (en)  q <= q + 1'b1;
   end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int RD_CYC    = 4,
   parameter int WR_CYC    = 4,
   parameter int FLOAT_CYC = 2,
   parameter int RCV_CYC   = 8,
   parameter int ACC_W     = 3,
   parameter int RCV_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             ret_req,
   input  logic [ACC_W-1:0] acc_cnt,
   input  logic [RCV_W-1:0] rcv_cnt,
   output logic             acc_clr,
   output logic             acc_en,
   output logic             rcv_clr,
   output logic             rcv_en,
   output logic             req_ready,
   output logic             accept,
   output logic             cap,
   output logic             sel_q,
   output logic             we_q,
   output logic             drv_q,
   output logic             ret_q,
   output logic             rcv_q,
   output logic             rvalid_q,
   output logic             wdone_q
);

   localparam logic [ACC_W-1:0] RD_LAST = ACC_W'(RD_CYC - 1);
   localparam logic [ACC_W-1:0] WR_LAST = ACC_W'(WR_CYC - 1);
   localparam logic [ACC_W-1:0] FLT_V   = ACC_W'(FLOAT_CYC);
   localparam logic [RCV_W-1:0] RCV_LAST = RCV_W'(RCV_CYC - 1);

   seq_state_t       st, st_d;
   logic [ACC_W-1:0] acc_nx;
   logic             wr_end;

   always_comb begin
      st_d      = st;
      req_ready = (st == ST_IDLE) && !ret_req;
      accept    = req_ready && req_valid;
      cap       = (st == ST_READ) && (acc_cnt == RD_LAST);
      wr_end    = (st == ST_WRITE) && (acc_cnt == WR_LAST);
      unique case (st)
         ST_IDLE: begin
            if (ret_req)        st_d = ST_RET;
            else if (req_valid) st_d = req_write ? ST_WRITE : ST_READ;
         end
         ST_READ:  if (acc_cnt == RD_LAST)  st_d = ST_IDLE;
         ST_WRITE: if (acc_cnt == WR_LAST)  st_d = ST_IDLE;
         ST_RET:   if (!ret_req)            st_d = ST_RCV;
         ST_RCV:   if (rcv_cnt == RCV_LAST) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   assign acc_clr = (st == ST_IDLE);
   assign acc_en  = (st == ST_READ) || (st == ST_WRITE);
   assign rcv_clr = (st == ST_RET);
   assign rcv_en  = (st == ST_RCV);
   assign acc_nx  = (st == ST_IDLE) ? '0 : acc_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sel_q    <= 1'b0;
         we_q     <= 1'b0;
         drv_q    <= 1'b0;
         ret_q    <= 1'b0;
         rcv_q    <= 1'b0;
         rvalid_q <= 1'b0;
         wdone_q  <= 1'b0;
      end else begin
         st       <= st_d;
         sel_q    <= (st_d == ST_READ) || (st_d == ST_WRITE);
         we_q     <= (st_d == ST_WRITE);
         drv_q    <= (st_d == ST_WRITE) && (acc_nx >= FLT_V);
         ret_q    <= (st_d == ST_RET);
         rcv_q    <= (st_d == ST_RCV);
         rvalid_q <= cap;
         wdone_q  <= wr_end;
      end
   end

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins #(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter int RET_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              sel_q,
   input  logic              we_q,
   input  logic              drv_q,
   input  logic              ret_q,
   input  logic              cap,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_ce,
   output logic              sram_we_n,
   inout  wire  [DATA_W-1:0] sram_dq,
   output logic [DATA_W-1:0] rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (cap) rdata <= sram_dq;
      end
   end

   assign sram_addr = addr_q;
   assign sram_ce_n = !sel_q;
   assign sram_we_n = !we_q;
   assign sram_dq   = drv_q ? wdata_q : 'z;

   // Retention polarity: which select is parked inactive.
   if (RET_STYLE == 0) begin : g_ret_ce_low
      assign sram_ce = !ret_q;
   end else begin : g_ret_cen_high
      assign sram_ce = 1'b1;
   end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter int CLK_PS    = 20000,
   parameter int T_RC_PS   = 70000,
   parameter int T_AA_PS   = 70000,
   parameter int T_WC_PS   = 70000,
   parameter int T_WP_PS   = 55000,
   parameter int T_WHZ_PS  = 30000,
   parameter int T_DW_PS   = 30000,
   parameter int T_RCV_NS  = 5000000,
   parameter int RET_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_rvalid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_wdone,
   input  logic              ret_req,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_ce,
   output logic              sram_we_n,
   inout  wire  [DATA_W-1:0] sram_dq
);

   localparam int RD_CYC    = imax(cycles_for(T_RC_PS, CLK_PS), cycles_for(T_AA_PS, CLK_PS));
   localparam int FLOAT_CYC = cycles_for(T_WHZ_PS, CLK_PS);
   localparam int DW_CYC    = cycles_for(T_DW_PS, CLK_PS);
   localparam int WR_CYC    = imax(imax(cycles_for(T_WC_PS, CLK_PS), cycles_for(T_WP_PS, CLK_PS)),
                                   FLOAT_CYC + DW_CYC);
   localparam int RCV_CYC   = cycles_for(longint'(T_RCV_NS) * 1000, CLK_PS);
   localparam int ACC_W     = $clog2(imax(RD_CYC, WR_CYC) + 1);
   localparam int RCV_W     = $clog2(RCV_CYC + 1);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_seq_ctrl: address and data widths must be positive");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("sram_seq_ctrl: clock period must be positive");
   end
   if (RET_STYLE < 0 || RET_STYLE > 1) begin : g_bad_style
      $error("sram_seq_ctrl: RET_STYLE must be 0 or 1");
   end

   logic             acc_clr, acc_en, rcv_clr, rcv_en, accept, cap;
   logic             sel_q, we_q, drv_q, ret_q, rcv_q;
   logic [ACC_W-1:0] acc_cnt;
   logic [RCV_W-1:0] rcv_cnt;

   sram_seq_count #(.W(ACC_W)) u_acc_cnt (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en), .q(acc_cnt)
   );

   sram_seq_count #(.W(RCV_W)) u_rcv_cnt (
      .clk(clk), .rst_n(rst_n), .clr(rcv_clr), .en(rcv_en), .q(rcv_cnt)
   );

   sram_seq_fsm #(
      .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .FLOAT_CYC(FLOAT_CYC),
      .RCV_CYC(RCV_CYC), .ACC_W(ACC_W), .RCV_W(RCV_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .ret_req(ret_req),
      .acc_cnt(acc_cnt), .rcv_cnt(rcv_cnt),
      .acc_clr(acc_clr), .acc_en(acc_en), .rcv_clr(rcv_clr), .rcv_en(rcv_en),
      .req_ready(req_ready), .accept(accept), .cap(cap),
      .sel_q(sel_q), .we_q(we_q), .drv_q(drv_q), .ret_q(ret_q), .rcv_q(rcv_q),
      .rvalid_q(rsp_rvalid), .wdone_q(rsp_wdone)
   );

   sram_seq_pins #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RET_STYLE(RET_STYLE)
   ) u_pins (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .sel_q(sel_q), .we_q(we_q), .drv_q(drv_q), .ret_q(ret_q), .cap(cap),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
      .sram_we_n(sram_we_n), .sram_dq(sram_dq), .rdata(rsp_rdata)
   );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
   parameter int ADDR_W    = 15,
   parameter int FLOAT_CYC = 2,
   parameter int WR_CYC    = 4,
   parameter int RET_STYLE = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce_n,
   input logic              sram_ce,
   input logic              sram_we_n,
   input logic              drv_en,
   input logic              ret_on,
   input logic              rcv_on,
   input logic              req_ready,
   input logic              rsp_rvalid,
   input logic              rsp_wdone
);

   localparam int LW = $clog2(WR_CYC + 2);

   // Cycles the write strobe has been low before the current cycle.
   logic [LW-1:0] lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lo_cnt <= '0;
      else if (sram_we_n)      lo_cnt <= '0;
      else if (lo_cnt != '1)   lo_cnt <= lo_cnt + 1'b1;
   end

   AST_READY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> sram_ce_n);                                         // R2
   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rvalid |=> !rsp_rvalid);                                      // R3
   AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (lo_cnt == LW'(WR_CYC)));                    // R4
   AST_WDONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wdone |-> ($past(!sram_we_n) && sram_we_n));                  // R4
   AST_DRV_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (!sram_ce_n && !sram_we_n));                           // R5
   AST_DRV_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (lo_cnt >= LW'(FLOAT_CYC)));                           // R5
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));        // R6
   AST_RET_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ret_on |-> (!req_ready && sram_ce_n));                            // R7
   AST_RCV_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_on |-> (!req_ready && sram_ce_n));                            // R8

   if (RET_STYLE == 0) begin : g_chk_ce_low
      AST_RET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
         ret_on |-> !sram_ce);                                          // R7
   end else begin : g_chk_cen_high
      AST_RET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
         ret_on |-> sram_ce);                                           // R7
   end

endmodule

bind sram_seq_ctrl sram_seq_chk #(
   .ADDR_W(ADDR_W), .FLOAT_CYC(FLOAT_CYC), .WR_CYC(WR_CYC), .RET_STYLE(RET_STYLE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
   .sram_ce(sram_ce), .sram_we_n(sram_we_n), .drv_en(drv_q), .ret_on(ret_q),
   .rcv_on(rcv_q), .req_ready(req_ready), .rsp_rvalid(rsp_rvalid),
   .rsp_wdone(rsp_wdone)
);

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

   localparam int EXP_RD    = 4;
   localparam int EXP_WR    = 4;
   localparam int EXP_FLOAT = 2;
   localparam int EXP_RCV   = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_rvalid, rsp_wdone;
   logic [7:0]  rsp_rdata;
   logic [14:0] sram_addr;
   logic        sram_ce_n, sram_ce, sram_we_n;
   wire  [7:0]  sram_dq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   sram_seq_ctrl #(.T_RCV_NS(800)) u_sram_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .rsp_wdone(rsp_wdone),
      .ret_req(ret_req), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
      .sram_ce(sram_ce), .sram_we_n(sram_we_n), .sram_dq(sram_dq)
   );

   // RAM model: drives while selected with strobe high; commits at end of write.
   logic [7:0]  ram_mem [int];
   logic [7:0]  ram_q = '0, wr_hold = '0;
   logic [14:0] wr_addr = '0;
   bit          wr_pend = 1'b0;
   wire         ram_sel = !sram_ce_n && sram_ce;
   assign sram_dq = (ram_sel && sram_we_n) ? ram_q : 'z;

   always @(negedge clk) begin
      ram_q <= ram_mem.exists(int'(sram_addr)) ? ram_mem[int'(sram_addr)] : 8'h00;
      if (ram_sel && !sram_we_n) begin
         wr_hold <= sram_dq;
         wr_addr <= sram_addr;
         wr_pend <= 1'b1;
      end else if (wr_pend) begin
         ram_mem[int'(wr_addr)] = wr_hold;
         wr_pend <= 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Scoreboard
   logic [7:0] exp_q [$];
   logic [7:0] exp_mem [int];

   always @(negedge clk) begin
      if (rst_n && rsp_rvalid) begin
         if (exp_q.size() == 0) check(1'b0, "R3 unexpected rvalid", 1, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rsp_rdata == e, "R9 read data", int'(rsp_rdata), int'(e));
         end
      end
   end

   task automatic do_write(input logic [14:0] a, input logic [7:0] d);
      int n = 0; bit seen = 0, addr_ok = 1, dat_ok = 1;
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
      exp_mem[int'(a)] = d;
      for (int k = 0; k < 20 && !seen; k++) begin
         @(negedge clk);
         if (k == 0) req_valid = 0;
         if (!sram_ce_n && !sram_we_n) begin
            n++;
            if (sram_addr != a) addr_ok = 0;
            if (n > EXP_FLOAT && sram_dq != d) dat_ok = 0;
         end
         if (rsp_wdone) begin
            seen = 1;
            check(sram_we_n, "R4 done after strobe", int'(sram_we_n), 1);
         end
      end
      check(n == EXP_WR, "R4 strobe cycles", n, EXP_WR);
      check(seen, "R4 wdone", int'(seen), 1);
      check(addr_ok, "R6 address held", int'(sram_addr), int'(a));
      check(dat_ok, "R5 bus driven with write byte", int'(sram_dq), int'(d));
   endtask

   task automatic do_read(input logic [14:0] a);
      int n = 0; bit seen = 0, addr_ok = 1;
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a;
      exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00);
      for (int k = 0; k < 20 && !seen; k++) begin
         @(negedge clk);
         if (k == 0) req_valid = 0;
         if (!sram_ce_n && sram_we_n) begin
            n++;
            if (sram_addr != a) addr_ok = 0;
         end
         if (rsp_rvalid) begin
            seen = 1;
            check(sram_ce_n, "R6 deselected after access", int'(sram_ce_n), 1);
         end
      end
      check(n == EXP_RD, "R3 read cycles", n, EXP_RD);
      check(seen, "R3 rvalid", int'(seen), 1);
      check(addr_ok, "R6 address held", int'(sram_addr), int'(a));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      bit sel_seen;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(req_ready, "R1 ready", int'(req_ready), 1);
      check(sram_ce_n && sram_ce && sram_we_n, "R1 pins",
            int'({sram_ce_n, sram_ce, sram_we_n}), 7);
      check(!rsp_rvalid && !rsp_wdone, "R1 responses",
            int'({rsp_rvalid, rsp_wdone}), 0);

      // R3 R4 R5 R6 R9 patterns
      do_write(15'h0000, 8'hA5);
      do_write(15'h7FFF, 8'h5A);
      do_write(15'h1234, 8'hFF);
      do_write(15'h0001, 8'h00);
      do_read(15'h7FFF);
      do_read(15'h0000);
      do_read(15'h0001);
      do_read(15'h1234);
      do_write(15'h1234, 8'h3C);   // R9 overwrite
      do_read(15'h1234);
      do_read(15'h1234);

      // R7: retention with a request valid in the same cycle
      while (!req_ready) @(negedge clk);
      ret_req = 1; req_valid = 1; req_write = 1; req_addr = 15'h0055; req_wdata = 8'hEE;
      @(negedge clk);
      check(!req_ready, "R7 ready low in retention", int'(req_ready), 0);
      check(!sram_ce && sram_ce_n, "R7 retention pins", int'({sram_ce_n, sram_ce}), 2);
      repeat (5) @(negedge clk);
      check(!sram_ce && sram_ce_n && sram_we_n, "R7 retention held",
            int'({sram_ce_n, sram_ce, sram_we_n}), 5);

      // R8: recovery lockout with the request still held valid
      ret_req = 0;
      n = 0; sel_seen = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (req_ready) break;
         n++;
         if (!sram_ce_n) sel_seen = 1;
      end
      check(n == EXP_RCV, "R8 recovery cycles", n, EXP_RCV);
      check(!sel_seen, "R8 no access in recovery", int'(sel_seen), 0);
      check(sram_ce, "R7 select restored", int'(sram_ce), 1);
      req_valid = 0;
      do_read(15'h0055);           // R7: held request never reached the RAM

      // R7: retention request while a read is in flight
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 15'h7FFF;
      exp_q.push_back(exp_mem[int'(15'h7FFF)]);
      @(negedge clk);
      req_valid = 0; ret_req = 1;
      check(!sram_ce_n && sram_ce, "R7 in-flight access continues",
            int'({sram_ce_n, sram_ce}), 1);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (rsp_rvalid) break;
      end
      @(negedge clk);
      check(!sram_ce && sram_ce_n, "R7 retention after access",
            int'({sram_ce_n, sram_ce}), 2);
      ret_req = 0;
      do_read(15'h0000);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule